// File: doc/BRIEF.md
# Byte-Ring Transmit Frame Fetcher

This block is the device-side consumer of one contiguous transmit ring. Software packs frame records into the ring back to back. Each record is a 4-byte length header followed by the payload, and each record starts on a 32-bit boundary. Software then raises a producer index. The fetcher keeps its own consumer byte offset and walks the ring from it. For each record it reads the header word and streams the payload as bytes on a valid/ready/last interface. A payload that runs past the top of the ring continues at offset 0. When the frame is done, the block posts one completion entry to a separate status ring.

Ring memory is reached through a synchronous word read port with one cycle of latency. Status memory is reached through a single-cycle write port. The producer index is counted in 32-bit words. An enable input decides whether a new record may be started. A record whose length is zero or larger than the maximum frame size is not streamed. It is completed at once with a failure status, and the fetcher moves past its header only.

Top module: `txring_fetch`

## Requirements
- R1: After a synchronous reset, `rd_en`, `st_we` and `out_valid` are low, the consumer offset is 0 and the first completion goes to status slot 0.
- R2: The header is the ring word at the record start, and its bits 15:0 hold the payload length. Payload bytes start at record start + 4 and leave in ring order. The byte at ring offset o is taken from bits 8*(o mod 4)+7 : 8*(o mod 4) of word o/4.
- R3: A record is pending only while the consumer byte offset differs from 4 × `prod_idx`. When the two are equal, no ring read is issued and nothing is output.
- R4: `out_last` is high with the final payload byte of each frame and with no other byte.
- R5: While `out_valid` is high and `out_ready` is low, `out_data`, `out_last` and `out_valid` hold their values.
- R6: Each record produces exactly one single-cycle status write. `st_data` bit 17 is the update flag (always 1), bit 16 is success and bits 15:0 are the length. The slot index starts at 0 and rises by one per record, modulo 64.
- R7: After a good frame of length L starting at offset s, the next record starts at (s + L + 7) with bits 1:0 cleared, modulo 8192.
- R8: A payload that passes offset 8191 continues at offset 0 with no gap in the byte order.
- R9: A header length of 0, or one above 1522, yields no output bytes. It yields a status entry with success 0 and that length, and the next record is taken from s + 4. A length of exactly 1522 is a good frame.
- R10: While `en` is low, no new record is started, even when one is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Allows new records to be started |
| prod_idx | input | 11 | Producer position in 32-bit words |
| rd_en | output | 1 | Ring word read request |
| rd_addr | output | 11 | Ring word address |
| rd_data | input | 32 | Ring word, valid the cycle after the request is sampled |
| st_we | output | 1 | Status entry write strobe |
| st_addr | output | 6 | Status slot index |
| st_data | output | 18 | {update, success, length[15:0]} |
| out_data | output | 8 | Payload byte |
| out_valid | output | 1 | Byte is valid |
| out_last | output | 1 | Byte is the last of the frame |
| out_ready | input | 1 | Sink accepts the byte |

## Verification
Suppose the producer index moves away from the consumer offset while enabled. The header read request then appears after the next edge. The header word is used two edges after that, and the first payload byte is valid four edges after the request was raised. Every later word costs three cycles of fetch before its bytes appear. A status write strobes for one cycle after the edge that accepted the final byte, or after the edge that judged a bad header, and the bench memory model stores it one edge later. The bench therefore samples at falling edges only. It polls each expected result cycle by cycle with a bounded wait, rather than at a fixed offset. During stalls it compares each held byte with the value from the cycle before.

// File: rtl/txf_pkg.sv
package txf_pkg;
  localparam int LEN_W  = 16;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int STAT_W = LEN_W + 2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HREQ,
    S_HWAIT,
    S_PREQ,
    S_PWAIT,
    S_SEND
  } fetch_state_t;

  typedef struct packed {
    logic             upd;
    logic             ok;
    logic [LEN_W-1:0] len;
  } stat_entry_t;
endpackage

// File: rtl/txf_hdr_check.sv
module txf_hdr_check
  import txf_pkg::*;
#(
  parameter int OFF_W   = 13,
  parameter int MAX_LEN = 1522
) (
  input  logic [LEN_W-1:0] len_raw,
  input  logic [OFF_W-1:0] start,
  output logic             bad,
  output logic [OFF_W-1:0] next_good,
  output logic [OFF_W-1:0] next_bad
);
  // Record = 4-byte header + payload, rounded up to a word; offsets wrap
  // naturally because the ring size is a power of two.
  always_comb begin
    bad       = (len_raw == '0) || (32'(len_raw) > 32'(MAX_LEN));
    next_good = (start + OFF_W'(len_raw) + OFF_W'(7)) & ~OFF_W'(3);
    next_bad  = start + OFF_W'(4);
  end
endmodule

// File: rtl/txf_byte_shift.sv
module txf_byte_shift
  import txf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              shift,
  output logic [BYTE_W-1:0] byte_o
);
  logic [WORD_W-1:0] sh_q;

  // Lowest lane leaves first: little-endian byte order within a word.
  always_ff @(posedge clk) begin
    if (rst)        sh_q <= '0;
    else if (load)  sh_q <= word;
    else if (shift) sh_q <= {{BYTE_W{1'b0}}, sh_q[WORD_W-1:BYTE_W]};
  end

  assign byte_o = sh_q[BYTE_W-1:0];
endmodule

// File: rtl/txf_stat_post.sv
module txf_stat_post
  import txf_pkg::*;
#(
  parameter int SIDX_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              post,
  input  logic              ok,
  input  logic [LEN_W-1:0]  len,
  output logic              st_we,
  output logic [SIDX_W-1:0] st_addr,
  output logic [STAT_W-1:0] st_data
);
  logic [SIDX_W-1:0] idx_q;
  stat_entry_t       ent_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_we   <= 1'b0;
      st_addr <= '0;
      idx_q   <= '0;
      ent_q   <= '0;
    end else begin
      st_we <= post;
      if (post) begin
        st_addr   <= idx_q;
        idx_q     <= idx_q + SIDX_W'(1);
        ent_q.upd <= 1'b1;
        ent_q.ok  <= ok;
        ent_q.len <= len;
      end
    end
  end

  assign st_data = ent_q;
endmodule

// File: rtl/txring_fetch.sv
module txring_fetch
  import txf_pkg::*;
#(
  parameter int RING_BYTES = 8192,
  parameter int STAT_DEPTH = 64,
  parameter int MAX_LEN    = 1522,
  localparam int OFF_W     = $clog2(RING_BYTES),
  localparam int WIDX_W    = OFF_W - 2,
  localparam int SIDX_W    = $clog2(STAT_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [WIDX_W-1:0] prod_idx,
  output logic              rd_en,
  output logic [WIDX_W-1:0] rd_addr,
  input  logic [31:0]       rd_data,
  output logic              st_we,
  output logic [SIDX_W-1:0] st_addr,
  output logic [STAT_W-1:0] st_data,
  output logic [7:0]        out_data,
  output logic              out_valid,
  output logic              out_last,
  input  logic              out_ready
);
  fetch_state_t      state_q;
  logic [OFF_W-1:0]  cons_q, next_q;
  logic [WIDX_W-1:0] pw_q;
  logic [LEN_W-1:0]  len_q, rem_q;
  logic [1:0]        lane_q;

  logic [OFF_W-1:0]  prod_off, hdr_next_good, hdr_next_bad;
  logic [LEN_W-1:0]  hdr_len, post_len;
  logic              hdr_bad, pending, fin_bad, fin_ok, take, word_end, frame_end;

  assign prod_off  = {prod_idx, 2'b00};
  assign pending   = (cons_q != prod_off);
  assign hdr_len   = rd_data[LEN_W-1:0];
  assign take      = (state_q == S_SEND) && out_ready;
  assign frame_end = (rem_q == LEN_W'(1));
  assign word_end  = (lane_q == 2'd3);
  assign fin_bad   = (state_q == S_HWAIT) && hdr_bad;
  assign fin_ok    = take && frame_end;
  assign post_len  = fin_ok ? len_q : hdr_len;

  txf_hdr_check #(.OFF_W(OFF_W), .MAX_LEN(MAX_LEN)) u_hdr (
    .len_raw   (hdr_len),
    .start     (cons_q),
    .bad       (hdr_bad),
    .next_good (hdr_next_good),
    .next_bad  (hdr_next_bad)
  );

  txf_byte_shift u_shift (
    .clk    (clk),
    .rst    (rst),
    .load   (state_q == S_PWAIT),
    .word   (rd_data),
    .shift  (take && !frame_end && !word_end),
    .byte_o (out_data)
  );

  txf_stat_post #(.SIDX_W(SIDX_W)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .post    (fin_bad || fin_ok),
    .ok      (fin_ok),
    .len     (post_len),
    .st_we   (st_we),
    .st_addr (st_addr),
    .st_data (st_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      cons_q    <= '0;
      next_q    <= '0;
      pw_q      <= '0;
      len_q     <= '0;
      rem_q     <= '0;
      lane_q    <= '0;
      rd_en     <= 1'b0;
      rd_addr   <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      rd_en <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (en && pending) begin
            rd_en   <= 1'b1;
            rd_addr <= cons_q[OFF_W-1:2];
            state_q <= S_HREQ;
          end
        end
        S_HREQ: state_q <= S_HWAIT;
        S_HWAIT: begin
          if (hdr_bad) begin
            cons_q  <= hdr_next_bad;
            state_q <= S_IDLE;
          end else begin
            len_q   <= hdr_len;
            rem_q   <= hdr_len;
            next_q  <= hdr_next_good;
            pw_q    <= cons_q[OFF_W-1:2] + WIDX_W'(1);
            rd_en   <= 1'b1;
            rd_addr <= cons_q[OFF_W-1:2] + WIDX_W'(1);
            state_q <= S_PREQ;
          end
        end
        S_PREQ: state_q <= S_PWAIT;
        S_PWAIT: begin
          out_valid <= 1'b1;
          out_last  <= (rem_q == LEN_W'(1));
          lane_q    <= '0;
          state_q   <= S_SEND;
        end
        S_SEND: begin
          if (out_ready) begin
            if (frame_end) begin
              out_valid <= 1'b0;
              out_last  <= 1'b0;
              cons_q    <= next_q;
              state_q   <= S_IDLE;
            end else if (word_end) begin
              out_valid <= 1'b0;
              out_last  <= 1'b0;
              rem_q     <= rem_q - LEN_W'(1);
              pw_q      <= pw_q + WIDX_W'(1);
              rd_en     <= 1'b1;
              rd_addr   <= pw_q + WIDX_W'(1);
              state_q   <= S_PREQ;
            end else begin
              rem_q    <= rem_q - LEN_W'(1);
              lane_q   <= lane_q + 2'd1;
              out_last <= (rem_q == LEN_W'(2));
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txring_fetch_chk.sv
module txring_fetch_chk #(
  parameter int SIDX_W  = 6,
  parameter int MAX_LEN = 1522
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              st_we,
  input logic [SIDX_W-1:0] st_addr,
  input logic [17:0]       st_data,
  input logic [7:0]        out_data,
  input logic              out_valid,
  input logic              out_last,
  input logic              out_ready
);
  logic [SIDX_W-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst)        seen_q <= '0;
    else if (st_we) seen_q <= seen_q + SIDX_W'(1);
  end

  a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  a_r4_last_closes: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_last && out_ready |=> !out_valid);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    st_we |=> !st_we);

  a_r6_update_flag: assert property (@(posedge clk) disable iff (rst)
    st_we |-> st_data[17]);

  a_r6_slot_order: assert property (@(posedge clk) disable iff (rst)
    st_we |-> st_addr == seen_q);

  a_r9_fail_cause: assert property (@(posedge clk) disable iff (rst)
    st_we && !st_data[16] |-> (st_data[15:0] == 16'd0) || (32'(st_data[15:0]) > 32'(MAX_LEN)));

  a_r3_one_read: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en);
endmodule

bind txring_fetch txring_fetch_chk #(.SIDX_W(SIDX_W), .MAX_LEN(MAX_LEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_en     (rd_en),
  .st_we     (st_we),
  .st_addr   (st_addr),
  .st_data   (st_data),
  .out_data  (out_data),
  .out_valid (out_valid),
  .out_last  (out_last),
  .out_ready (out_ready)
);

// File: tb/txring_fetch_test.sv
module txring_fetch_test;
  localparam int RB = 8192;
  localparam int SD = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [10:0] prod_idx = '0;
  logic        rd_en;
  logic [10:0] rd_addr;
  logic [31:0] rd_data = '0;
  logic        st_we;
  logic [5:0]  st_addr;
  logic [17:0] st_data;
  logic [7:0]  out_data;
  logic        out_valid, out_last;
  logic        out_ready = 1'b1;

  logic [31:0] ring [0:RB/4-1];
  logic [17:0] smem [0:SD-1];
  int st_cnt = 0;
  int checks = 0;
  int errs = 0;
  int wp = 0;
  int sidx = 0;

  always #5 clk = ~clk;

  txring_fetch uut (
    .clk(clk), .rst(rst), .en(en), .prod_idx(prod_idx),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .st_we(st_we), .st_addr(st_addr), .st_data(st_data),
    .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
    .out_ready(out_ready)
  );

  // Ring and status memory models
  always @(posedge clk) begin
    if (rd_en) rd_data <= ring[rd_addr];
    if (st_we) begin
      smem[st_addr] <= st_data;
      st_cnt <= st_cnt + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  function automatic int pat(input int seed, input int i);
    return (seed * 13 + i * 7 + 1) & 255;
  endfunction

  task automatic put_byte(input int off, input int b);
    int o = off % RB;
    ring[o / 4][8 * (o % 4) +: 8] = b[7:0];
  endtask

  // Write a record at wp: header word, then plen payload bytes
  task automatic put_record(input int hdr, input int seed, input int plen);
    ring[(wp % RB) / 4] = hdr;
    for (int i = 0; i < plen; i++) put_byte(wp + 4 + i, pat(seed, i));
    if (plen > 0) wp = ((wp + plen + 7) & ~3) % RB;
    else wp = (wp + 4) % RB;
  endtask

  task automatic publish();
    @(negedge clk);
    prod_idx = 11'(wp / 4);
  endtask

  // Collect len bytes; mode 1 applies back-pressure
  task automatic collect(input int len, input int seed, input int mode, input string req);
    int got = 0, bad = 0, lastbad = 0, cyc = 0, base;
    int act_b = 0, exp_b = 0;
    logic stall = 1'b0;
    logic [7:0] held = '0;
    base = st_cnt;
    while (got < len && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (stall && out_data != held) bad++;
      out_ready = (mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      stall = out_valid && !out_ready;
      held = out_data;
      if (out_valid && out_ready) begin
        if (out_data != 8'(pat(seed, got)) && bad == 0) begin
          act_b = out_data;
          exp_b = pat(seed, got);
          bad++;
        end
        if (out_last != (got == len - 1)) lastbad++;
        got++;
      end
    end
    out_ready = 1'b1;
    check({req, " byte count"}, got, len);
    check({req, " payload bytes"}, (bad == 0) ? 0 : act_b + 256, (bad == 0) ? 0 : exp_b + 256);
    check("R4 last marker", lastbad, 0);
    cyc = 0;
    while (st_cnt == base && cyc < 50) begin
      @(negedge clk);
      cyc++;
    end
    check("R6 status entry", int'(smem[sidx % SD]), int'({2'b11, 16'(len)}));
    sidx++;
  endtask

  task automatic run_frame(input int len, input int seed, input int mode, input string req);
    put_record(len, seed, len);
    publish();
    collect(len, seed, mode, req);
  endtask

  task automatic quiet(input int n, input string req);
    int act = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rd_en || out_valid) act++;
    end
    check(req, act, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 rd_en low", int'(rd_en), 0);
    check("R1 out_valid low", int'(out_valid), 0);
    check("R1 st_we low", int'(st_we), 0);
    rst = 1'b0;
    en  = 1'b1;
  endtask

  task automatic t_basic();
    run_frame(5, 1, 0, "R1 R2 first frame");
    run_frame(1, 2, 0, "R2 single byte");
    run_frame(8, 3, 1, "R5 stalled");
    run_frame(13, 4, 1, "R5 stalled odd");
    quiet(20, "R3 idle when caught up");
  endtask

  task automatic bad_frame(input int len);
    int base = st_cnt, seen = 0, cyc = 0;
    put_record(len, 0, 0);
    publish();
    while (st_cnt == base && cyc < 50) begin
      @(negedge clk);
      cyc++;
      if (out_valid) seen++;
    end
    check("R9 no bytes for bad length", seen, 0);
    check("R9 fail status", int'(smem[sidx % SD]), int'({2'b10, 16'(len)}));
    sidx++;
  endtask

  task automatic t_bad();
    bad_frame(0);
    bad_frame(1600);
    run_frame(3, 5, 0, "R7 R9 resume after header");
    run_frame(1522, 6, 0, "R9 max length accepted");
    bad_frame(1523);
    run_frame(2, 7, 0, "R7 resume after 1523");
  endtask

  task automatic t_enable();
    en = 1'b0;
    put_record(6, 8, 6);
    publish();
    quiet(30, "R10 disabled holds");
    en = 1'b1;
    collect(6, 8, 0, "R10 resumes");
  endtask

  task automatic t_wrap();
    int g = 8184 - wp;
    while (g > 1508) begin
      run_frame(1500, 9, 0, "R7 filler");
      g = 8184 - wp;
    end
    run_frame(g - 4, 10, 0, "R7 filler tail");
    check("R7 record offset before wrap", wp, 8184);
    run_frame(20, 11, 1, "R8 wrap payload");
    check("R8 next record after wrap", wp, 16);
    run_frame(9, 12, 0, "R8 after wrap");
  endtask

  task automatic t_slots();
    for (int i = 0; i < 66; i++) run_frame(1 + (i % 4), 20 + i, 0, "R6 slot wrap");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_basic();
    t_bad();
    t_enable();
    t_wrap();
    t_slots();
    quiet(10, "R3 idle at end");
    summary();
  end
endmodule